// File: doc/BRIEF.md
# Multi-Mode Accelerator Data Shuffler

The shuffler sits between a memory-facing stream and a small group of accelerator slots. Each slot has a valid/ready stream into it and a result stream out of it. A three-bit mode code chooses how one inbound word or burst is handed out and how the results are put back together. In the redundant modes, two or three slots get the same word and their results are voted; in two of these modes one replica is a complemented dual-rail copy. In the parallel modes, successive words of a burst go to different slots, and the results come back either as a packed burst or folded into one value by add, unsigned maximum or unsigned minimum.

The voted, packed or reduced words leave on one output stream with a last flag and a three-bit error code. The mode, slot-enable mask and reduction operation are captured with the first word a transfer accepts and are held until the final output beat of that transfer is taken. Codes 6 and 7 are reserved and accept no input.

Top module: `accel_shuffler`

## Requirements
- R1: Mode, slot mask and reduction operation are captured when the first word of a transfer is accepted; changes on those inputs have no effect until the output beat carrying last=1 of that transfer is accepted.
- R2: In modes 0 to 3, each accepted word goes to the same cycle to the lowest two or three enabled slots (three when at least three are enabled; at least two must be enabled), and one output word is produced per input word.
- R3: With three replicas, the output is the value at least two replicas agree on. The error code is 0 when all three agree, and 1, 2 or 3 when the first, second or third replica (counted from the lowest slot number) disagrees alone. When all three differ, the first replica's value is output with error code 7.
- R4: With two replicas, matching results give error code 0, and a mismatch outputs the first replica's value with error code 7.
- R5: In modes 1 and 3, the highest-numbered replica returns the bitwise complement; the voter inverts it before comparing, so a healthy set gives the true result with error code 0.
- R6: In modes 0 and 1, every word is a transfer of its own: the input last flag is ignored and each output has last=1.
- R7: In modes 2 and 3, outputs follow the input order and each carries the last flag of the word it came from.
- R8: In mode 4, word i of a burst goes to the i-th enabled slot, counting cyclically from the lowest. Results return in input order with error code 0 and last=1 on the final word. A slot gets no new word while its previous result is unread.
- R9: In mode 5, the results of a burst are folded by operation code 00 wrapping add, 01 unsigned maximum, 10 unsigned minimum (11 acts as add). A single output with last=1 and error code 0 follows the final result.
- R10: After reset, no output is valid and no slot is offered a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Operating mode code 0..5 |
| slot_en | input | NSLOT | Slots taking part |
| red_op | input | 2 | Reduction operation for mode 5 |
| in_valid | input | 1 | Inbound word valid |
| in_ready | output | 1 | Inbound word accepted |
| in_data | input | DW | Inbound word |
| in_last | input | 1 | Final word of inbound burst |
| slot_in_valid | output | NSLOT | Per-slot word valid |
| slot_in_ready | input | NSLOT | Per-slot word ready |
| slot_in_data | output | NSLOT*DW | Per-slot word, slot s at bits s*DW |
| slot_res_valid | input | NSLOT | Per-slot result valid |
| slot_res_ready | output | NSLOT | Per-slot result taken |
| slot_res_data | input | NSLOT*DW | Per-slot result, slot s at bits s*DW |
| out_valid | output | 1 | Outbound word valid |
| out_ready | input | 1 | Outbound word accepted |
| out_data | output | DW | Voted, packed or reduced word |
| out_last | output | 1 | Final outbound word of transfer |
| out_err | output | 3 | Vote error code |

## Verification
On every cycle, the assertions check that a parallel mode offers a word to at most one slot and a redundant mode to no more than three. They also check that parallel-mode outputs carry error code 0, that the error code stays within its legal values, and that a reduction emits only a last-flagged beat. Whether the vote picks the right value and names the right dissenter, whether the complemented replica is undone, whether the cyclic slot order and folded values are right, and whether a mid-burst mode change is held off can only be shown by the bench. It does this by comparing every output beat against a behavioural model of slots with different latencies and injected faults.

// File: rtl/accel_shuffler.sv
module accel_shuffler #(
  parameter int NSLOT = 4,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_sel,
  input  logic [NSLOT-1:0]    slot_en,
  input  logic [1:0]          red_op,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DW-1:0]       in_data,
  input  logic                in_last,
  output logic [NSLOT-1:0]    slot_in_valid,
  input  logic [NSLOT-1:0]    slot_in_ready,
  output logic [NSLOT*DW-1:0] slot_in_data,
  input  logic [NSLOT-1:0]    slot_res_valid,
  output logic [NSLOT-1:0]    slot_res_ready,
  input  logic [NSLOT*DW-1:0] slot_res_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic                out_last,
  output logic [2:0]          out_err
);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [NSLOT-1:0] ONE = NSLOT'(1);
  typedef logic [IW-1:0] idx_t;

  function automatic idx_t next_en(idx_t p, logic [NSLOT-1:0] en);
    idx_t r = p;
    for (int k = NSLOT - 1; k >= 1; k--)
      if (en[(int'(p) + k) % NSLOT]) r = idx_t'((int'(p) + k) % NSLOT);
    return r;
  endfunction

  function automatic logic [DW-1:0] fold(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      2'b01:   return (a > b) ? a : b;
      2'b10:   return (a < b) ? a : b;
      default: return a + b;
    endcase
  endfunction

  logic             busy, in_done, acc_has;
  logic [2:0]       act_mode;
  logic [1:0]       act_op;
  logic [NSLOT-1:0] act_en, pend, tag;
  idx_t             dptr, cptr;
  logic [DW-1:0]    acc;

  wire [2:0]       mode = busy ? act_mode : mode_sel;
  wire [NSLOT-1:0] en   = busy ? act_en : slot_en;
  wire is_rep    = mode <= 3'd3;
  wire is_blk    = (mode == 3'd4) || (mode == 3'd5);
  wire is_red    = mode == 3'd5;
  wire is_single = mode <= 3'd1;
  wire is_dual   = (mode == 3'd1) || (mode == 3'd3);

  logic [NSLOT-1:0] rep_sel;
  idx_t ra, rb, rc;
  logic three;
  always_comb begin
    int cnt;
    cnt = 0; rep_sel = '0; ra = '0; rb = '0; rc = '0;
    for (int s = 0; s < NSLOT; s++)
      if (en[s]) begin
        if (cnt == 0) ra = idx_t'(s);
        else if (cnt == 1) rb = idx_t'(s);
        else if (cnt == 2) rc = idx_t'(s);
        if (cnt < 3) rep_sel[s] = 1'b1;
        cnt++;
      end
    three = cnt >= 3;
  end

  wire idx_t dp = busy ? dptr : ra;
  wire rep_free = &(~rep_sel | (slot_in_ready & ~pend));
  wire blk_free = slot_in_ready[dp] & ~pend[dp] & en[dp];
  assign in_ready = !(busy && in_done) && (is_rep ? rep_free : (is_blk && blk_free));
  wire acc_in = in_valid && in_ready;
  wire start  = acc_in && !busy;
  assign slot_in_valid = !acc_in ? '0 : (is_rep ? rep_sel : (ONE << dp));
  assign slot_in_data  = {NSLOT{in_data}};

  wire [DW-1:0] va = slot_res_data[int'(ra)*DW +: DW];
  wire [DW-1:0] vb = slot_res_data[int'(rb)*DW +: DW] ^ {DW{is_dual && !three}};
  wire [DW-1:0] vc = slot_res_data[int'(rc)*DW +: DW] ^ {DW{is_dual && three}};
  wire [DW-1:0] vcur = slot_res_data[int'(cptr)*DW +: DW];
  logic [DW-1:0] vote;
  logic [2:0]    verr;
  always_comb begin
    vote = va; verr = 3'd0;
    if (!three)            verr = (va == vb) ? 3'd0 : 3'd7;
    else if (va == vb)     verr = (va == vc) ? 3'd0 : 3'd3;
    else if (va == vc)     verr = 3'd2;
    else if (vb == vc) begin vote = vb; verr = 3'd1; end
    else                   verr = 3'd7;
  end

  wire rep_rv   = &(~rep_sel | slot_res_valid);
  wire red_val  = acc_has ? fold(act_op, acc, vcur) : vcur;
  wire [DW-1:0] red_word = acc_has ? fold(act_op, acc, vcur) : vcur;
  wire blk_take = is_red ? (!tag[cptr] || out_ready) : out_ready;
  assign out_valid = busy && (is_rep ? rep_rv : (is_blk && slot_res_valid[cptr] && (!is_red || tag[cptr])));
  assign out_data  = is_rep ? vote : (is_red ? red_word : vcur);
  assign out_last  = is_rep ? tag[ra] : (is_red || tag[cptr]);
  assign out_err   = is_rep ? verr : 3'd0;
  assign slot_res_ready = !busy ? '0 :
                          is_rep ? ((rep_rv && out_ready) ? rep_sel : '0) :
                          (is_blk && blk_take) ? (ONE << cptr) : '0;
  wire [NSLOT-1:0] res_fire = slot_res_valid & slot_res_ready;
  wire done = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; in_done <= 1'b0; acc_has <= 1'b0;
      act_mode <= '0; act_op <= '0; act_en <= '0;
      pend <= '0; tag <= '0; dptr <= '0; cptr <= '0; acc <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1; act_mode <= mode_sel; act_en <= slot_en; act_op <= red_op; cptr <= ra;
      end else if (busy && is_blk && |res_fire) cptr <= next_en(cptr, act_en);
      if (acc_in && (is_single || in_last)) in_done <= 1'b1;
      if (done) begin busy <= 1'b0; in_done <= 1'b0; end
      pend <= (pend | slot_in_valid) & ~res_fire;
      for (int s = 0; s < NSLOT; s++)
        if (slot_in_valid[s]) tag[s] <= is_single || in_last;
      if (acc_in && is_blk) dptr <= next_en(dp, en);
      if (busy && is_red && |res_fire) begin
        acc_has <= !tag[cptr];
        acc     <= red_word;
      end
    end
  end

  AST_BLK_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) is_blk |-> $onehot0(slot_in_valid)); // R8
  AST_REP_GROUP_SIZE: assert property (@(posedge clk) disable iff (!rst_n) is_rep |-> $countones(slot_in_valid) <= 3); // R2
  AST_BLK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && act_mode >= 3'd4) |-> out_err == 3'd0); // R8
  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_err <= 3'd3 || out_err == 3'd7)); // R3
  AST_RED_LAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && act_mode == 3'd5) |-> out_last); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !out_valid); // R10

  logic unused_ok;
  assign unused_ok = ^{red_val};
endmodule

// File: tb/accel_shuffler_tb.sv
`timescale 1ns/1ps
module accel_shuffler_tb_top;
  localparam int N = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]      mode_sel = '0;
  logic [N-1:0]    slot_en = '1;
  logic [1:0]      red_op = '0;
  logic            in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [DW-1:0]   in_data = '0;
  logic [N-1:0]    slot_in_valid, slot_in_ready, slot_res_valid, slot_res_ready;
  logic [N*DW-1:0] slot_in_data, slot_res_data;
  logic            out_valid, out_ready = 1'b0, out_last;
  logic [DW-1:0]   out_data;
  logic [2:0]      out_err;

  accel_shuffler #(.NSLOT(N), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .slot_en(slot_en), .red_op(red_op),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .slot_in_valid(slot_in_valid), .slot_in_ready(slot_in_ready), .slot_in_data(slot_in_data),
    .slot_res_valid(slot_res_valid), .slot_res_ready(slot_res_ready), .slot_res_data(slot_res_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_err(out_err));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] f(input logic [DW-1:0] x);
    return DW'(x * 16'd5 + 16'd3);
  endfunction
  function automatic logic [DW-1:0] xin(input int base, input int i);
    return DW'(base * 97 + i * 4099);
  endfunction

  // behavioural slot models: latency s+1, optional fault mask and complement
  logic [DW-1:0] fmask [N];
  logic [N-1:0]  dual = '0;
  logic [N-1:0]  sb;
  int            sc [N];
  logic [DW-1:0] sr [N];
  assign slot_in_ready = ~sb;
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot_res_valid[g] = sb[g] && (sc[g] == 0);
    assign slot_res_data[g*DW +: DW] = sr[g];
  end
  always @(posedge clk) begin
    for (int s = 0; s < N; s++) begin
      if (!rst_n) begin sb[s] <= 1'b0; sc[s] <= 0; sr[s] <= '0; end
      else if (slot_in_valid[s] && !sb[s]) begin
        sb[s] <= 1'b1; sc[s] <= s + 1;
        sr[s] <= f(slot_in_data[s*DW +: DW]) ^ fmask[s] ^ {DW{dual[s]}};
      end else begin
        if (sc[s] != 0) sc[s] <= sc[s] - 1;
        if (slot_res_valid[s] && slot_res_ready[s]) sb[s] <= 1'b0;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= (cyc % 4) != 3;
  end

  logic [DW+3:0] exp_q [$];
  string         req_q [$];
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected output", {out_err, out_last, out_data}, 0);
      else begin
        logic [DW+3:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({out_err, out_last, out_data} == e, r, {out_err, out_last, out_data}, e);
      end
    end
  end

  task automatic push_exp(input logic [2:0] e, input logic l, input logic [DW-1:0] d, input string r);
    exp_q.push_back({e, l, d});
    req_q.push_back(r);
  endtask

  task automatic send_word(input logic [DW-1:0] d, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
  endtask

  task automatic drain(input string req);
    int t = 0;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    chk(exp_q.size() == 0, {req, " all outputs seen"}, exp_q.size(), 0);
    exp_q.delete(); req_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_rep(input logic [2:0] m, input logic [N-1:0] en, input int n, input int base, input string req);
    int sl [3];
    int k = 0;
    for (int s = 0; s < N; s++) if (en[s] && k < 3) begin sl[k] = s; k++; end
    mode_sel = m; slot_en = en; dual = '0;
    if (m == 3'd1 || m == 3'd3) dual[sl[k-1]] = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] v [3];
      logic [DW-1:0] d;
      logic [2:0] e;
      for (int j = 0; j < k; j++) v[j] = f(xin(base, i)) ^ fmask[sl[j]];
      d = v[0];
      if (k == 2) e = (v[0] == v[1]) ? 3'd0 : 3'd7;
      else if (v[0] == v[1] && v[1] == v[2]) e = 3'd0;
      else begin
        e = 3'd7;
        for (int j = 0; j < 3; j++)
          if (v[(j+1)%3] == v[(j+2)%3]) begin d = v[(j+1)%3]; e = 3'(j + 1); end
      end
      push_exp(e, (m <= 3'd1) ? 1'b1 : (i == n - 1), d, req);
    end
    for (int i = 0; i < n; i++) send_word(xin(base, i), (m <= 3'd1) ? 1'b0 : (i == n - 1));
    drain(req);
    dual = '0;
  endtask

  task automatic run_blk(input logic [2:0] m, input logic [N-1:0] en, input int n, input int base,
                         input logic [1:0] op, input bit chg, input string req);
    logic [DW-1:0] r;
    mode_sel = m; slot_en = en; red_op = op;
    r = f(xin(base, 0));
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] v;
      v = f(xin(base, i));
      if (m == 3'd4) push_exp(3'd0, i == n - 1, v, req);
      else if (i > 0) begin
        if (op == 2'b01) r = (v > r) ? v : r;
        else if (op == 2'b10) r = (v < r) ? v : r;
        else r = r + v;
      end
    end
    if (m == 3'd5) push_exp(3'd0, 1'b1, r, req);
    for (int i = 0; i < n; i++) begin
      send_word(xin(base, i), i == n - 1);
      if (chg && i == 1) begin mode_sel = 3'd0; slot_en = 4'b0011; red_op = 2'b10; end
    end
    drain(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) fmask[s] = '0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(slot_in_valid == '0, "R10 slot_in_valid after reset", slot_in_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid idle", out_valid, 0);

    run_rep(3'd0, 4'b1111, 3, 1, "R2 R6 three replicas agree");
    fmask[1] = 16'h0040;
    run_rep(3'd0, 4'b1111, 2, 2, "R3 second replica dissents");
    fmask[1] = '0; fmask[0] = 16'h8001;
    run_rep(3'd0, 4'b1111, 2, 3, "R3 first replica dissents");
    fmask[0] = '0; fmask[2] = 16'h0100;
    run_rep(3'd0, 4'b1111, 2, 4, "R3 third replica dissents");
    fmask[2] = '0; fmask[0] = 16'h0001; fmask[1] = 16'h0002;
    run_rep(3'd0, 4'b0111, 2, 5, "R3 all replicas differ");
    fmask[0] = '0; fmask[1] = '0;
    run_rep(3'd0, 4'b1010, 2, 6, "R4 two replicas agree");
    fmask[3] = 16'h2000;
    run_rep(3'd0, 4'b1010, 2, 7, "R4 two replicas mismatch");
    fmask[3] = '0;
    run_rep(3'd1, 4'b0111, 3, 8, "R5 R6 dual-rail single");
    fmask[2] = 16'h0800;
    run_rep(3'd1, 4'b0111, 2, 9, "R5 dual-rail replica faulty");
    fmask[2] = '0; fmask[0] = 16'h0004;
    run_rep(3'd2, 4'b1111, 5, 10, "R7 burst replica");
    fmask[0] = '0;
    run_rep(3'd3, 4'b1011, 4, 11, "R5 R7 burst dual-rail");
    run_rep(3'd3, 4'b0011, 3, 12, "R5 R7 burst dual-rail two replicas");

    run_blk(3'd4, 4'b1101, 7, 13, 2'b00, 1'b0, "R8 block burst");
    run_blk(3'd4, 4'b0100, 3, 14, 2'b00, 1'b0, "R8 block burst one slot");
    run_blk(3'd5, 4'b1111, 6, 15, 2'b00, 1'b0, "R9 reduce add");
    run_blk(3'd5, 4'b1111, 5, 16, 2'b01, 1'b0, "R9 reduce max");
    run_blk(3'd5, 4'b1011, 5, 17, 2'b10, 1'b0, "R9 reduce min");
    run_blk(3'd5, 4'b1111, 4, 18, 2'b11, 1'b0, "R9 reduce code 11 adds");
    run_blk(3'd5, 4'b0110, 1, 19, 2'b01, 1'b0, "R9 reduce single word");

    fmask[1] = 16'h0010;
    run_blk(3'd4, 4'b1101, 6, 20, 2'b00, 1'b1, "R1 mode change mid-burst held");
    run_rep(3'd0, 4'b0011, 1, 21, "R1 new mode after burst");
    fmask[1] = '0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule